// File: doc/BRIEF.md
# Receive FIFO Pause Flow Controller

This block tracks how much data sits in a receive FIFO and asks the MAC transmitter to emit flow-control frames. Occupancy is kept in bus data units. A unit is 4 bytes when the bus is 32 bits wide and 8 bytes when it is 64 bits wide. Each packet written into or read out of the FIFO is reported as a byte count, and any trailing partial unit is rounded up to a whole unit.

When flow control is enabled and occupancy climbs past the high level, the block raises a request that carries the programmed pause time. It also arms a hysteresis bit. While that bit is armed, a later drop of occupancy below the low level raises a second request that carries a zero timer, which releases the link partner, and the bit disarms. Each request is held until the transmitter acknowledges it. A condition that arrives while a request is still pending replaces that request. Frame formatting and the FIFO storage sit outside this block.

Top module: `rxq_pause_ctrl`

## Requirements
- R1: After reset, `req_valid` is 0, `req_timer` is 0, occupancy is zero and the block is disarmed.
- R2: A write of N bytes adds ceil(N/4) units when `bus_wide`=0 and ceil(N/8) units when `bus_wide`=1. A read removes units by the same rule. A byte count of 0 changes nothing.
- R3: With `fc_enable`=1 and the block disarmed, if occupancy is greater than `hi_level`+1, then at the next clock edge `req_valid` rises, `req_timer` takes the value of `pause_time` and the block arms. Occupancy updates on the clock edge that samples a write, so the request appears one edge after that.
- R4: While the block is armed, no further pause-time request is made, however high occupancy stays.
- R5: With `fc_enable`=1 and the block armed, if occupancy is less than `lo_level`+1, then at the next edge `req_valid` rises, `req_timer` becomes 0 and the block disarms.
- R6: If occupancy stays at or below `hi_level`+1, no zero-timer request is made, however far occupancy falls.
- R7: A request stays asserted with a stable timer until an edge samples `req_ack`=1. That edge clears it, unless a new condition fires at the same edge.
- R8: A new condition that fires while a request is pending overwrites `req_timer` with the new value and keeps `req_valid` high.
- R9: `fc_enable`=0 clears `req_valid` and disarms the block at the next edge, without making a zero-timer request. Occupancy tracking continues while flow control is disabled.
- R10: Occupancy is a 12-bit count that saturates at 4095 and at 0. A write and a read in the same cycle are both applied, and the combined change is clamped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fc_enable | input | 1 | Transmit flow control enable |
| bus_wide | input | 1 | 0: 4-byte unit, 1: 8-byte unit |
| wr_en | input | 1 | A packet was written this cycle |
| wr_bytes | input | 14 | Byte count of the written packet |
| rd_en | input | 1 | A packet was read this cycle |
| rd_bytes | input | 14 | Byte count of the read packet |
| hi_level | input | 11 | High level, in units |
| lo_level | input | 11 | Low level, in units (software keeps lo_level <= hi_level) |
| pause_time | input | 16 | Timer value carried by the pause request |
| req_valid | output | 1 | Flow-control frame request |
| req_timer | output | 16 | Timer value of the pending request |
| req_ack | input | 1 | Transmitter accepts the pending request |

## Verification
The hardest situation to reach from the ports is a saturated occupancy count. Telling it apart from a wrapped or wider count needs thousands of units pushed in and then nearly all of them drained. The stimulus writes three 2048-unit packets, then reads back exactly 4094 units. If the count saturated, the zero-timer request fires at a low level of 1. If the count wrapped or grew wider, it does not fire. A second hard case is a zero-timer condition that arrives before the pause request has been acknowledged. The bench reaches it by withholding the acknowledge while occupancy is emptied.

// File: rtl/rxq_pause_pkg.sv
package rxq_pause_pkg;

  // Number of whole bus units needed to hold nbytes (partial unit rounds up).
  function automatic int ceil_units(input int nbytes, input logic wide);
    int shift;
    shift = wide ? 3 : 2;
    return (nbytes + (1 << shift) - 1) >> shift;
  endfunction

  // Add and subtract in one step, then clamp into [0, maxval].
  function automatic int clamp_step(input int cur, input int add, input int sub,
                                    input int maxval);
    int s;
    s = cur + add - sub;
    if (s < 0) s = 0;
    if (s > maxval) s = maxval;
    return s;
  endfunction

endpackage

// File: rtl/rxq_unit_conv.sv
module rxq_unit_conv #(
  parameter int BYTE_W = 14,
  parameter int UNIT_W = BYTE_W - 1
) (
  input  logic              en,
  input  logic [BYTE_W-1:0] nbytes,
  input  logic              wide,
  output logic [UNIT_W-1:0] units
);
  import rxq_pause_pkg::*;

  int raw;

  always_comb begin
    raw   = ceil_units(int'(nbytes), wide);
    units = en ? UNIT_W'(raw) : '0;
  end
endmodule

// File: rtl/rxq_occ_counter.sv
module rxq_occ_counter #(
  parameter int BYTE_W = 14,
  parameter int OCC_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_bytes,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] rd_bytes,
  input  logic              bus_wide,
  output logic [OCC_W-1:0]  occ
);
  import rxq_pause_pkg::*;

  localparam int UNIT_W  = BYTE_W - 1;
  localparam int OCC_MAX = (1 << OCC_W) - 1;
  localparam int LANES   = 2;

  logic              lane_en    [LANES];
  logic [BYTE_W-1:0] lane_bytes [LANES];
  logic [UNIT_W-1:0] lane_units [LANES];

  assign lane_en[0]    = wr_en;
  assign lane_bytes[0] = wr_bytes;
  assign lane_en[1]    = rd_en;
  assign lane_bytes[1] = rd_bytes;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rxq_unit_conv #(.BYTE_W(BYTE_W), .UNIT_W(UNIT_W)) u_conv (
      .en     (lane_en[g]),
      .nbytes (lane_bytes[g]),
      .wide   (bus_wide),
      .units  (lane_units[g])
    );
  end

  // Named events for checking.
  logic [UNIT_W-1:0] inc_units, dec_units;
  assign inc_units = lane_units[0];
  assign dec_units = lane_units[1];

  int occ_next;
  always_comb
    occ_next = clamp_step(int'(occ), int'(inc_units), int'(dec_units), OCC_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= OCC_W'(occ_next);
  end

  // R10
  occ_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(occ) == OCC_MAX && inc_units >= dec_units) |=> (int'(occ) == OCC_MAX));

  // R10
  occ_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(dec_units) >= int'(occ) + int'(inc_units)) |=> (occ == '0));

endmodule

// File: rtl/rxq_level_cmp.sv
module rxq_level_cmp #(
  parameter int OCC_W = 12,
  parameter int LVL_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] occ,
  input  logic [LVL_W-1:0] hi_level,
  input  logic [LVL_W-1:0] lo_level,
  output logic             above_hi,
  output logic             below_lo
);
  localparam int CW = ((OCC_W > LVL_W) ? OCC_W : LVL_W) + 1;

  logic [CW-1:0] occ_x, hi_lim, lo_lim;

  // Each level counts as its register value plus one unit.
  assign occ_x  = CW'(occ);
  assign hi_lim = CW'(hi_level) + CW'(1);
  assign lo_lim = CW'(lo_level) + CW'(1);

  assign above_hi = occ_x > hi_lim;
  assign below_lo = occ_x < lo_lim;

  // R3 R5: with ordered levels both conditions can never hold together
  level_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_level <= hi_level) |-> !(above_hi && below_lo));

endmodule

// File: rtl/rxq_req_ctrl.sv
module rxq_req_ctrl #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             above_hi,
  input  logic             below_lo,
  input  logic [TMR_W-1:0] pause_time,
  input  logic             ack,
  output logic             req_valid,
  output logic [TMR_W-1:0] req_timer
);
  logic armed;
  logic evt_pause, evt_zero, evt_any, evt_ack;

  assign evt_pause = en && !armed && above_hi;
  assign evt_zero  = en &&  armed && below_lo;
  assign evt_any   = evt_pause || evt_zero;
  assign evt_ack   = req_valid && ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      req_valid <= 1'b0;
      req_timer <= '0;
    end else if (!en) begin
      armed     <= 1'b0;
      req_valid <= 1'b0;
    end else if (evt_pause) begin
      armed     <= 1'b1;
      req_valid <= 1'b1;
      req_timer <= pause_time;
    end else if (evt_zero) begin
      armed     <= 1'b0;
      req_valid <= 1'b1;
      req_timer <= '0;
    end else if (evt_ack) begin
      req_valid <= 1'b0;
    end
  end

  // R3 R8
  pause_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !armed && above_hi) |=> (req_valid && armed && req_timer == $past(pause_time)));

  // R5 R8
  zero_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && armed && below_lo) |=> (req_valid && !armed && req_timer == '0));

  // R4 R7
  no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && armed && !below_lo && !ack) |=> ($stable(req_valid) && $stable(req_timer) && armed));

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && req_valid && ack && !(above_hi && !armed) && !(below_lo && armed)) |=> !req_valid);

  // R9
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!req_valid && !armed));

endmodule

// File: rtl/rxq_pause_ctrl.sv
module rxq_pause_ctrl #(
  parameter int BYTE_W = 14,
  parameter int OCC_W  = 12,
  parameter int LVL_W  = 11,
  parameter int TMR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fc_enable,
  input  logic              bus_wide,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_bytes,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] rd_bytes,
  input  logic [LVL_W-1:0]  hi_level,
  input  logic [LVL_W-1:0]  lo_level,
  input  logic [TMR_W-1:0]  pause_time,
  output logic              req_valid,
  output logic [TMR_W-1:0]  req_timer,
  input  logic              req_ack
);
  logic [OCC_W-1:0] occ;
  logic             above_hi, below_lo;

  rxq_occ_counter #(.BYTE_W(BYTE_W), .OCC_W(OCC_W)) u_occ (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_bytes (wr_bytes),
    .rd_en    (rd_en),
    .rd_bytes (rd_bytes),
    .bus_wide (bus_wide),
    .occ      (occ)
  );

  rxq_level_cmp #(.OCC_W(OCC_W), .LVL_W(LVL_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .occ      (occ),
    .hi_level (hi_level),
    .lo_level (lo_level),
    .above_hi (above_hi),
    .below_lo (below_lo)
  );

  rxq_req_ctrl #(.TMR_W(TMR_W)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (fc_enable),
    .above_hi   (above_hi),
    .below_lo   (below_lo),
    .pause_time (pause_time),
    .ack        (req_ack),
    .req_valid  (req_valid),
    .req_timer  (req_timer)
  );
endmodule

// File: tb/sim_rxq_pause_ctrl.sv
`timescale 1ns/1ps
module sim_rxq_pause_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fc_enable = 1'b0, bus_wide = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, req_ack = 1'b0;
  logic [13:0] wr_bytes = '0, rd_bytes = '0;
  logic [10:0] hi_level = 11'h7FF, lo_level = 11'h000;
  logic [15:0] pause_time = 16'h0000;
  logic        req_valid;
  logic [15:0] req_timer;

  int    n_vec = 0, n_bad = 0;
  bit    finished = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  rxq_pause_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .fc_enable(fc_enable), .bus_wide(bus_wide),
    .wr_en(wr_en), .wr_bytes(wr_bytes), .rd_en(rd_en), .rd_bytes(rd_bytes),
    .hi_level(hi_level), .lo_level(lo_level), .pause_time(pause_time),
    .req_valid(req_valid), .req_timer(req_timer), .req_ack(req_ack)
  );

  // Reference model derived from the requirements.
  int          m_occ;
  bit          m_armed, m_valid;
  logic [15:0] m_timer;

  function automatic int to_units(int n, bit wide);
    int u;
    u = wide ? 8 : 4;
    return n / u + ((n % u) != 0 ? 1 : 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    int add, sub, nxt;
    bit over_c, under_c;
    if (!rst_n) begin
      m_occ <= 0; m_armed <= 0; m_valid <= 0; m_timer <= 16'h0;
    end else begin
      add = wr_en ? to_units(int'(wr_bytes), bus_wide) : 0;
      sub = rd_en ? to_units(int'(rd_bytes), bus_wide) : 0;
      over_c  = (m_occ - 1) > int'(hi_level);
      under_c = (m_occ - 1) < int'(lo_level);
      if (!fc_enable) begin
        m_armed <= 0; m_valid <= 0;
      end else if (!m_armed && over_c) begin
        m_armed <= 1; m_valid <= 1; m_timer <= pause_time;
      end else if (m_armed && under_c) begin
        m_armed <= 0; m_valid <= 1; m_timer <= 16'h0;
      end else if (m_valid && req_ack) begin
        m_valid <= 0;
      end
      nxt = m_occ + add - sub;
      if (nxt > 4095) nxt = 4095;
      if (nxt < 0) nxt = 0;
      m_occ <= nxt;
    end
  end

  task automatic check(string t, logic av, logic [15:0] at, logic ev, logic [15:0] et);
    n_vec++;
    if (av !== ev || at !== et) begin
      n_bad++;
      $display("FAIL %s: actual valid=%0b timer=%h expected valid=%0b timer=%h at %0t",
               t, av, at, ev, et, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    check(tag, req_valid, req_timer, m_valid, m_timer);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic push(int nb);
    wr_en = 1'b1; wr_bytes = 14'(nb); step(); wr_en = 1'b0;
  endtask

  task automatic pop(int nb);
    rd_en = 1'b1; rd_bytes = 14'(nb); step(); rd_en = 1'b0;
  endtask

  task automatic drain();
    req_ack = 1'b1; step(); req_ack = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin : stim
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    tag = "R1";
    check("R1", req_valid, req_timer, 1'b0, 16'h0);
    rst_n = 1'b1;
    idle(2);

    // R2 sweep: rounding in both bus modes against several high levels
    tag = "R2";
    pause_time = 16'h5A3C;
    for (int w = 0; w < 2; w++) begin
      bus_wide = w[0];
      for (int h = 0; h < 7; h++) begin
        hi_level = 11'(h); lo_level = 11'h0;
        for (int b = 0; b <= 60; b++) begin
          fc_enable = 1'b1;
          push(b); idle(2); drain();
          pop(b); idle(2); drain();
          fc_enable = 1'b0; step(); fc_enable = 1'b1;
        end
      end
    end

    // R6: rise without passing the high level, then fall: no release frame
    tag = "R6";
    bus_wide = 1'b0; hi_level = 11'd8; lo_level = 11'd3; pause_time = 16'h1234;
    for (int i = 0; i < 9; i++) push(4);
    for (int i = 0; i < 9; i++) pop(4);
    idle(3);

    // R3 / R4 / R5: cross high, stay high, fall below low
    tag = "R3";
    for (int i = 0; i < 10; i++) push(4);
    idle(3); drain();
    tag = "R4";
    for (int i = 0; i < 5; i++) push(4);
    idle(3);
    tag = "R5";
    for (int i = 0; i < 13; i++) pop(4);
    idle(2); drain(); idle(2);

    // R7 / R8: hold without ack, then newer condition replaces
    tag = "R7";
    hi_level = 11'd2; lo_level = 11'd1; pause_time = 16'hBEEF;
    push(12); idle(2);
    push(4); idle(6);
    tag = "R8";
    pop(16); idle(4); drain(); idle(2);

    // R9: disable drops pending request and disarms without release
    tag = "R9";
    pause_time = 16'h0F0F;
    push(16); idle(2);
    fc_enable = 1'b0; step(); step(); fc_enable = 1'b1;
    pop(16); idle(4);

    // R10: saturation high, then low, and simultaneous write/read
    tag = "R10";
    hi_level = 11'h7FF; lo_level = 11'd1; pause_time = 16'h7777;
    push(8192); push(8192); push(8192); idle(2); drain();
    pop(16376); idle(2); drain();
    pop(400); idle(2);
    hi_level = 11'd0; lo_level = 11'd0;
    push(4); idle(2);
    push(4); idle(2); drain();
    wr_en = 1'b1; rd_en = 1'b1; wr_bytes = 14'd8; rd_bytes = 14'd12; step();
    wr_bytes = 14'd12; rd_bytes = 14'd4; step();
    wr_en = 1'b0; rd_en = 1'b0; idle(2); drain();
    pop(64); idle(3); drain();

    // R3/R8 random mix across both modes
    tag = "R8";
    lf = 32'hACE1_2345;
    hi_level = 11'd6; lo_level = 11'd2;
    for (int i = 0; i < 6000; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      wr_en = lf[0]; wr_bytes = 14'(lf[7:2]);
      rd_en = lf[8]; rd_bytes = 14'(lf[14:9]);
      req_ack = lf[15] & lf[16];
      fc_enable = (lf[21:17] != 5'd0);
      if (i % 500 == 0) bus_wide = ~bus_wide;
      pause_time = lf[31:16];
      step();
    end
    wr_en = 1'b0; rd_en = 1'b0; req_ack = 1'b0;
    idle(3);
    summary();
  end
endmodule